// File: doc/BRIEF.md
# Microwire Command Master

This block is a half-duplex serial master for command/response exchanges with a Microwire-style peripheral. Each message opens by lowering chip select and shifting out an 8- or 16-bit command word. The master then clocks in a response word of 4 to 16 bits while its own data output is held low. The serial clock runs only inside a message and stays low at other times. Its half period is `HALF_DIV` cycles of the system clock.

A request carries the command word, the command width and the response length. It is taken on a valid/ready handshake. The configuration inputs are read at the moment a request is accepted:

- timing format;
- bit order;
- chip-select hold extension of 0 to 3 bit periods;
- back-to-back enable.

When a message ends, the received word is presented with a one-cycle strobe.

In format 1 with back-to-back enabled, a request that is waiting when the last response bit has been clocked is chained. Chip select stays low and the next command starts on the clock's next falling edge.

Top module: `mw_cmd_master`

## Requirements
- R1: After reset and while idle, mw_cs_n is 1, mw_sck is 0, mw_so is 0, rsp_valid is 0 and req_ready is 1.
- R2: The command length N is 16 when req_wide is 1 (all of req_cmd) and 8 when it is 0 (req_cmd[7:0]). With cfg_lsb_first = 1 bit 0 is sent first; with 0 the top bit of the selected width is sent first. The first bit appears on mw_so when mw_cs_n falls, each later bit on a falling mw_sck edge, and each bit is stable across the following rising edge.
- R3: mw_sck is 0 while mw_cs_n is 1. Its first rise comes HALF_DIV clock cycles after mw_cs_n falls, and successive mw_sck edges inside a message are HALF_DIV cycles apart.
- R4: Format 1 (cfg_fmt2 = 0): the peripheral presents response bit k after falling edge N+1+k, and the master samples mw_si on rising edge N+2+k. A message has N+L+1 rising edges.
- R5: Format 2 (cfg_fmt2 = 1): the peripheral presents response bit k on rising edge N+1+k, and the master samples it on the falling edge that follows. A message has N+L rising edges.
- R6: With response length L = req_len (4 to 16), rsp_data holds the L received bits right-aligned, with the upper bits 0. The first received bit is the most significant when cfg_lsb_first = 0 and the least significant when it is 1. rsp_valid pulses for one cycle once per message.
- R7: mw_so is 0 from the end of the command until the message ends.
- R8: With H = cfg_hold, mw_cs_n stays low for (2N+2L+2+2H)·HALF_DIV cycles in format 1 and for (2N+2L+1+2H)·HALF_DIV cycles in format 2.
- R9: While a message runs, req_ready is 0 except at the chaining point of R10. In the cycle after an acceptance, req_ready is 0 and mw_cs_n is 0.
- R10: In format 1 with cfg_chain = 1, a request that is valid when the falling edge after the last response rise is due is accepted there. mw_cs_n stays low, the hold extension is skipped, and the new command starts on that edge. The first message then contributes (2N+2L+2)·HALF_DIV cycles to the chip-select low time.
- R11: In format 2, cfg_chain has no effect: mw_cs_n returns high before the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt2 | input | 1 | 0 = format 1, 1 = format 2 |
| cfg_lsb_first | input | 1 | Bit order for command and response |
| cfg_hold | input | 2 | Extra chip-select hold, in bit periods |
| cfg_chain | input | 1 | Allow back-to-back chaining (format 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_cmd | input | CMD_W | Command word |
| req_wide | input | 1 | 1 = CMD_W-bit command, 0 = CMD_W/2-bit command |
| req_len | input | LW | Response length in bits |
| rsp_valid | output | 1 | One-cycle strobe, response ready |
| rsp_data | output | RSP_W | Received response, right-aligned |
| mw_sck | output | 1 | Serial clock |
| mw_cs_n | output | 1 | Chip select, active low |
| mw_so | output | 1 | Serial data to the peripheral |
| mw_si | input | 1 | Serial data from the peripheral |

## Verification
The bench sweeps every combination of format, bit order, command width, each response length from 4 to 16 and each hold value. A peripheral model captures the command on rising edges and returns a pattern-derived word on the edge its format dictates. An off-by-one in the turnaround or in the sampling edge therefore shows up as a shifted response, and a wrong bit order shows up as a reversed command or response. Each chip-select window is timed and its rising clock edges are counted, which separates the hold, format and half-period rules. Chains of three format 1 messages check the kept chip select and the shortened first window. The same request pattern sent in format 2 checks that chaining is refused there.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic {
    FMT_ONE = 1'b0,
    FMT_TWO = 1'b1
  } mw_fmt_e;

  typedef struct packed {
    mw_fmt_e    fmt;
    logic       lsb;
    logic [1:0] hold;
    logic       chain;
    logic       wide;
  } msg_cfg_t;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF_DIV - 1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift #(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             wide,
  input  logic             lsb,
  input  logic [CMD_W-1:0] word,
  output logic             bit_o
);
  localparam int HW = CMD_W / 2;

  logic [CMD_W-1:0] sr_q, sr_d, fill;
  logic             lsb_q, lsb_d;

  always_comb begin
    if (wide)     fill = word;
    else if (lsb) fill = {{(CMD_W-HW){1'b0}}, word[HW-1:0]};
    else          fill = {word[HW-1:0], {(CMD_W-HW){1'b0}}};
    sr_d  = sr_q;
    lsb_d = lsb_q;
    if (load) begin
      sr_d  = fill;
      lsb_d = lsb;
    end else if (shift) begin
      sr_d = lsb_q ? (sr_q >> 1) : (sr_q << 1);
    end
    bit_o = lsb_q ? sr_q[0] : sr_q[CMD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      lsb_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      lsb_q <= lsb_d;
    end
  end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int RSP_W = 16,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             din,
  input  logic             finish,
  input  logic             lsb,
  input  logic [LW-1:0]    len,
  output logic             valid_o,
  output logic [RSP_W-1:0] data_o
);
  logic [RSP_W-1:0] rx_q, rx_d;
  logic             fin_q;

  always_comb begin
    rx_d = rx_q;
    if (clear)       rx_d = '0;
    else if (sample) rx_d = lsb ? {din, rx_q[RSP_W-1:1]} : {rx_q[RSP_W-2:0], din};
    data_o  = lsb ? (rx_q >> (LW'(RSP_W) - len)) : rx_q;
    valid_o = fin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      rx_q  <= rx_d;
      fin_q <= finish;
    end
  end

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/mw_cmd_master.sv
module mw_cmd_master
  import mw_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CMD_W    = 16,
  parameter int RSP_W    = 16,
  parameter int LW       = $clog2(RSP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fmt2,
  input  logic             cfg_lsb_first,
  input  logic [1:0]       cfg_hold,
  input  logic             cfg_chain,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic             req_wide,
  input  logic [LW-1:0]    req_len,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data,
  output logic             mw_sck,
  output logic             mw_cs_n,
  output logic             mw_so,
  input  logic             mw_si
);
  localparam int PW = $clog2(2*CMD_W + 2*RSP_W + 9);

  logic [1:0]    rst_pipe;
  logic          rst_ni;
  logic          active_q, active_d, sck_q, sck_d, cs_n_q, cs_n_d;
  logic [PW-1:0] p_q, p_d, p_nxt;
  msg_cfg_t      cfg_q, cfg_d;
  logic [LW-1:0] len_q, len_d;
  logic [PW-1:0] nbits, lbits, body, hold2, chain_pt, clk_end, end_pt, first_smp, last_smp;
  logic          tick, step, fmt_two, smp, chain_ok, accept, tx_shift, rx_finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  mw_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_ni), .run(active_q), .tick(tick));

  always_comb begin
    nbits     = cfg_q.wide ? PW'(CMD_W) : PW'(CMD_W/2);
    lbits     = PW'(len_q);
    body      = (nbits << 1) + (lbits << 1);
    hold2     = PW'({cfg_q.hold, 1'b0});
    fmt_two   = (cfg_q.fmt == FMT_TWO);
    p_nxt     = p_q + 1'b1;
    chain_pt  = body + PW'(2);
    clk_end   = fmt_two ? body : chain_pt;
    end_pt    = (fmt_two ? body + PW'(1) : chain_pt) + hold2;
    first_smp = (nbits << 1) + (fmt_two ? PW'(2) : PW'(3));
    last_smp  = fmt_two ? body : body + PW'(1);
    step      = active_q && tick;
    smp       = step && (p_nxt >= first_smp) && (p_nxt <= last_smp) && (p_nxt[0] != fmt_two);
    chain_ok  = step && !fmt_two && cfg_q.chain && (p_nxt == chain_pt);
    req_ready = !active_q || chain_ok;
    accept    = req_valid && req_ready;
    tx_shift  = step && !p_nxt[0] && !accept;
    rx_finish = smp && (p_nxt == last_smp);

    active_d = active_q;
    p_d      = p_q;
    sck_d    = sck_q;
    cs_n_d   = cs_n_q;
    cfg_d    = cfg_q;
    len_d    = len_q;
    if (accept) begin
      active_d    = 1'b1;
      p_d         = '0;
      sck_d       = 1'b0;
      cs_n_d      = 1'b0;
      cfg_d.fmt   = cfg_fmt2 ? FMT_TWO : FMT_ONE;
      cfg_d.lsb   = cfg_lsb_first;
      cfg_d.hold  = cfg_hold;
      cfg_d.chain = cfg_chain;
      cfg_d.wide  = req_wide;
      len_d       = req_len;
    end else if (step) begin
      p_d   = p_nxt;
      sck_d = p_nxt[0] && (p_nxt < clk_end);
      if (p_nxt == end_pt) begin
        active_d = 1'b0;
        cs_n_d   = 1'b1;
        sck_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      p_q      <= '0;
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      cfg_q    <= '0;
      len_q    <= '0;
    end else begin
      active_q <= active_d;
      p_q      <= p_d;
      sck_q    <= sck_d;
      cs_n_q   <= cs_n_d;
      cfg_q    <= cfg_d;
      len_q    <= len_d;
    end
  end

  mw_tx_shift #(.CMD_W(CMD_W)) u_tx (
    .clk(clk), .rst_n(rst_ni), .load(accept), .shift(tx_shift),
    .wide(req_wide), .lsb(cfg_lsb_first), .word(req_cmd), .bit_o(mw_so));

  mw_rx_shift #(.RSP_W(RSP_W), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_ni), .clear(accept), .sample(smp), .din(mw_si),
    .finish(rx_finish), .lsb(cfg_q.lsb), .len(len_q),
    .valid_o(rsp_valid), .data_o(rsp_data));

  assign mw_sck  = sck_q;
  assign mw_cs_n = cs_n_q;

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mw_cs_n |-> !mw_sck);

  // R7
  so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_q && (p_q >= (nbits << 1))) |-> !mw_so);

  // R8
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q |-> !mw_cs_n);

  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && active_q) |=> (!mw_cs_n && !mw_sck));
endmodule

// File: tb/mw_cmd_master_test.sv
module mw_cmd_master_test;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_fmt2 = 0, cfg_lsb_first = 0, cfg_chain = 0, req_valid = 0, req_wide = 0;
  logic [1:0] cfg_hold = 0;
  logic [15:0] req_cmd = 0;
  logic [4:0] req_len = 4;
  logic mw_si = 0;
  logic req_ready, rsp_valid, mw_sck, mw_cs_n, mw_so;
  logic [15:0] rsp_data;

  mw_cmd_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt2(cfg_fmt2), .cfg_lsb_first(cfg_lsb_first),
    .cfg_hold(cfg_hold), .cfg_chain(cfg_chain), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .req_wide(req_wide), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mw_sck(mw_sck), .mw_cs_n(mw_cs_n),
    .mw_so(mw_so), .mw_si(mw_si));

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [15:0] d_cmd [0:1023];
  logic [15:0] d_resp[0:1023];
  int d_len[0:1023], d_w[0:1023], d_f2[0:1023], d_lsb[0:1023], d_hold[0:1023], d_ch[0:1023];
  int wr_idx = 0, st_idx = 0, rsp_idx = 0;

  task automatic send(input int cmd, input int w, input int len, input int f2,
                      input int lsb, input int h, input int ch);
    @(negedge clk);
    d_cmd[wr_idx] = 16'(cmd); d_w[wr_idx] = w; d_len[wr_idx] = len; d_f2[wr_idx] = f2;
    d_lsb[wr_idx] = lsb; d_hold[wr_idx] = h; d_ch[wr_idx] = ch;
    d_resp[wr_idx] = 16'((cmd * 40503 + wr_idx * 77 + 16'h5A3C) & 16'hFFFF);
    wr_idx++;
    req_cmd = 16'(cmd); req_wide = w[0]; req_len = 5'(len); cfg_fmt2 = f2[0];
    cfg_lsb_first = lsb[0]; cfg_hold = 2'(h); cfg_chain = ch[0];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !mw_cs_n, "R9 busy after accept", {req_ready, mw_cs_n}, 0);
  endtask

  // peripheral model
  bit armed = 1, seen_cs = 0, first_edge = 0, gap_bad = 0, so_bad = 0;
  int cur = 0, rc = 0, fc = 0, nb = 8, ln = 4, tot_r = 0, exp_tot = 0;
  longint exp_low = 0, t_cs = 0, t_edge = 0;
  logic [15:0] cap;

  task automatic start_msg(input bit chained);
    int i = st_idx;
    bit exp_ch = (i > 0) && (d_ch[i-1] != 0) && (d_f2[i-1] == 0);
    chk(chained == exp_ch, "R10 R11 chaining decision", chained, exp_ch);
    if (chained) exp_low -= 2 * d_hold[i-1] * HALF;
    cur = i; st_idx++;
    nb = d_w[i] ? 16 : 8;
    ln = d_len[i];
    exp_tot += nb + ln + (d_f2[i] ? 0 : 1);
    exp_low += (2*nb + 2*ln + (d_f2[i] ? 1 : 2) + 2*d_hold[i]) * HALF;
    rc = 0; fc = 0; cap = 0; so_bad = 0; armed = 0;
  endtask

  task automatic drive_bit(input int k);
    mw_si = d_lsb[cur] ? d_resp[cur][k] : d_resp[cur][ln-1-k];
  endtask

  always @(negedge mw_cs_n) begin
    seen_cs = 1; tot_r = 0; exp_tot = 0; exp_low = 0; t_cs = cyc;
    first_edge = 1; gap_bad = 0;
    if (armed) start_msg(1'b0);
    else chk(0, "R8 chip select fell inside a message", 0, 1);
  end

  always @(posedge mw_cs_n) if (seen_cs) begin
    chk(armed, "R4 R5 message completed before CS rose", armed, 1);
    chk(tot_r == exp_tot, "R4 R5 rising edges in CS window", tot_r, exp_tot);
    chk(cyc - t_cs == exp_low, "R8 CS low time", cyc - t_cs, exp_low);
    chk(!gap_bad, "R3 clock edge spacing", gap_bad, 0);
  end

  always @(mw_sck) if (!mw_cs_n) begin
    if (first_edge) begin
      if (cyc - t_cs != HALF) gap_bad = 1;
      first_edge = 0;
    end else if (cyc - t_edge != HALF) gap_bad = 1;
    t_edge = cyc;
  end

  always @(posedge mw_sck) begin
    if (mw_cs_n) chk(0, "R3 clock rose with CS high", 1, 0);
    else begin
      if (armed) start_msg(1'b1);
      tot_r++;
      rc++;
      if (rc <= nb) cap[d_lsb[cur] ? rc-1 : nb-rc] = mw_so;
      else if (mw_so !== 1'b0) so_bad = 1;
      if (d_f2[cur] != 0 && rc > nb && rc <= nb + ln) drive_bit(rc - nb - 1);
      if (rc == nb + ln + (d_f2[cur] ? 0 : 1)) begin
        chk(cap == (d_cmd[cur] & 16'((1 << nb) - 1)), "R2 command bits", cap,
            d_cmd[cur] & 16'((1 << nb) - 1));
        chk(!so_bad, "R7 data output low in response", so_bad, 0);
        armed = 1;
      end
    end
  end

  always @(negedge mw_sck) if (!armed) begin
    fc++;
    if (d_f2[cur] == 0 && fc > nb && fc <= nb + ln) drive_bit(fc - nb - 1);
  end

  always @(negedge clk) if (rsp_valid) begin
    logic [15:0] e;
    e = d_resp[rsp_idx] & 16'((1 << d_len[rsp_idx]) - 1);
    chk(rsp_data == e, "R6 response word (R4 R5 sampling)", rsp_data, e);
    rsp_idx++;
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mw_cs_n == 1, "R1 reset cs_n", mw_cs_n, 1);
    chk(mw_sck == 0, "R1 reset sck", mw_sck, 0);
    chk(mw_so == 0, "R1 reset so", mw_so, 0);
    chk(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);

    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++)
        for (int w = 0; w < 2; w++)
          for (int len = 4; len <= 16; len++)
            for (int h = 0; h < 4; h++)
              send(16'hC3A5 ^ (len * 291) ^ (h << 13) ^ (w << 6), w, len, f, l, h, 0);

    // R10: chained format 1 groups
    send(16'h9E37, 1, 16, 0, 0, 3, 1);
    send(16'h00B2, 0, 4,  0, 1, 1, 1);
    send(16'h7461, 1, 11, 0, 0, 2, 0);
    send(16'h1F0D, 0, 9,  0, 1, 0, 1);
    send(16'hA0C9, 0, 13, 0, 0, 0, 0);
    // R11: chaining requested in format 2 is refused
    send(16'h5D12, 1, 7,  1, 0, 0, 1);
    send(16'h33CC, 0, 12, 1, 1, 1, 1);
    send(16'hE801, 1, 5,  1, 0, 0, 0);

    while (!(mw_cs_n && armed)) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rsp_idx == wr_idx, "R6 one response per message", rsp_idx, wr_idx);
    chk(st_idx == wr_idx, "R9 every request started", st_idx, wr_idx);
    chk(mw_sck == 0 && mw_so == 0 && req_ready == 1, "R1 idle after traffic",
        {mw_sck, mw_so, req_ready}, 1);
    summary();
    $finish;
  end
endmodule